// File: doc/BRIEF.md
# Keyed System Control Register Bank

This block is a small bank of control registers for a development board. It sits on a simple 32-bit register bus with an offset, a write strobe, a read strobe and write data. Read data is returned one cycle after the read strobe.

Several of its writes are guarded:

- A reset control register accepts a write only after software has stored a magic unlock key in the lock register. An accepted write sends a one-cycle system reset request.
- A display control register takes a write through a mask. The mask is chosen by a 12-bit board identifier, which comes from a static system ID word on an input port.
- On one board, bits of the written display value also drive a 2-bit pixel format select output.

The bank also holds two set/clear flag registers, one volatile and one non-volatile, and a free-running counter that advances at 24 MHz. The counter is derived from the block clock by a fractional accumulator.

The board identifier is expected to stay constant between resets.

Top module: `sysctl_regs`

## Requirements
- R1: Writing exactly 0x0000A05F to offset 0x20 stores the unlock key. Any other write there stores only bits 14:0 of the data, which leaves the block locked. A read of 0x20 returns the stored 16-bit value in bits 15:0 and returns 1 in bit 16 when the block is unlocked. The stored value is zero after reset.
- R2: The board identifier is bits 27:16 of the `sys_id` input. The recognised codes are 0x100, 0x140, 0x178, 0x182 and 0x190.
- R3: A write to 0x30 ORs the data into the flag register, and a write to 0x34 clears every flag bit that is 1 in the data. Reading 0x30 returns the flags. Offsets 0x38 and 0x3C do the same for the non-volatile flags, which read at 0x38. Both flag registers are zero after reset.
- R4: On any board other than 0x190, a write to 0x40 while unlocked stores the data and sets `rst_req` high for exactly the one cycle after the write edge. A write to 0x40 while locked changes nothing and gives no request. A read of 0x40 returns the stored value, which is zero after reset.
- R5: On board 0x190, offset 0x40 reads zero and never raises `rst_req`, and the display register at 0x50 reads zero and ignores writes.
- R6: On boards 0x100 and 0x140, a write to 0x50 keeps bits 13:8 and replaces all other bits with the data.
- R7: `fmt_mux` takes bits 1:0 of every write to 0x50 on board 0x100. It is zero after reset and never changes on other boards.
- R8: On boards 0x178 and 0x182, a write to 0x50 replaces every bit except bit 7, which keeps its stored value.
- R9: After reset the display register reads 0x00001F00 on every board but 0x190. On board codes that are not recognised, writes to 0x50 are ignored.
- R10: Offset 0x5C returns a counter that advances by TICK_HZ/CLK_HZ counts per clock on average. With the defaults this is exactly 96 counts per 1000 cycles, and it never steps by more than one in a cycle.
- R11: Reads of any other offset return zero, and writes to them change no register. `bus_rdata` is updated only in the cycle after `bus_rd`, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_id | input | 32 | Static system ID word; board code in bits 27:16 |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle system reset request |
| fmt_mux | output | 2 | Display pixel format select |

## Verification
Some rules are checked by the assertions on every cycle:

- The reset request is a single-cycle pulse that only follows a write to 0x40 and never appears on board 0x190.
- The format select moves only after a display write on board 0x100.
- Read data holds when no read was issued.
- The counter never jumps by more than one.

Other rules can only be shown by the bench's scenarios, because they depend on the history of values: the key gating, the masked display writes for each board, the set/clear arithmetic of the flags, the exact counter rate, and the zero reads of unmapped offsets.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_A05F;

  localparam int OFF_LOCK     = 'h20;
  localparam int OFF_FLAG_SET = 'h30;
  localparam int OFF_FLAG_CLR = 'h34;
  localparam int OFF_NV_SET   = 'h38;
  localparam int OFF_NV_CLR   = 'h3C;
  localparam int OFF_RSTCTL   = 'h40;
  localparam int OFF_DISP     = 'h50;
  localparam int OFF_TICK     = 'h5C;

  localparam logic [11:0] BRD_A  = 12'h100;
  localparam logic [11:0] BRD_B  = 12'h140;
  localparam logic [11:0] BRD_C  = 12'h178;
  localparam logic [11:0] BRD_D  = 12'h182;
  localparam logic [11:0] BRD_VX = 12'h190;

  localparam logic [31:0] DISP_RESET  = 32'h0000_1F00;
  localparam logic [31:0] DISP_RO_AB  = 32'h0000_3F00;
  localparam logic [31:0] DISP_RO_CD  = 32'h0000_0080;
endpackage

// File: rtl/sysctl_flagpair.sv
module sysctl_flagpair #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst) val <= '0;
    else if (set_en) val <= val | wdata;
    else if (clr_en) val <= val & ~wdata;
  end
endmodule

// File: rtl/sysctl_tick.sv
module sysctl_tick #(
  parameter int CLK_HZ  = 250_000_000,
  parameter int TICK_HZ = 24_000_000,
  parameter int W       = 32
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] count
);
  localparam int ACC_W = $clog2(CLK_HZ) + 2;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(TICK_HZ);
  localparam logic [ACC_W-1:0] WRAP = ACC_W'(CLK_HZ);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_nx;

  assign acc_nx = acc + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      count <= '0;
    end else if (acc_nx >= WRAP) begin
      acc   <= acc_nx - WRAP;
      count <= count + 1'b1;
    end else begin
      acc <= acc_nx;
    end
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int CLK_HZ  = 250_000_000,
  parameter int TICK_HZ = 24_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       sys_id,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req,
  output logic [1:0]        fmt_mux
);
  localparam int NFLAG = 2;

  logic [11:0] board;
  assign board = sys_id[27:16];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  logic [15:0] key_q;
  logic        unlocked;
  assign unlocked = ({16'h0, key_q} == UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (rst) key_q <= '0;
    else if (bus_wr && hit(bus_addr, OFF_LOCK))
      key_q <= (bus_wdata == UNLOCK_KEY) ? UNLOCK_KEY[15:0] : {1'b0, bus_wdata[14:0]};
  end

  // flag pairs: index 0 volatile, 1 non-volatile
  logic [31:0] flag_val [NFLAG];
  generate
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
      localparam int SET_OFF = (g == 0) ? OFF_FLAG_SET : OFF_NV_SET;
      localparam int CLR_OFF = (g == 0) ? OFF_FLAG_CLR : OFF_NV_CLR;
      sysctl_flagpair #(.W(32)) u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_en (bus_wr && hit(bus_addr, SET_OFF)),
        .clr_en (bus_wr && hit(bus_addr, CLR_OFF)),
        .wdata  (bus_wdata),
        .val    (flag_val[g])
      );
    end
  endgenerate

  logic [31:0] rlev_q;
  logic        rst_take;
  assign rst_take = bus_wr && hit(bus_addr, OFF_RSTCTL) && unlocked && (board != BRD_VX);

  always_ff @(posedge clk) begin
    if (rst) begin
      rlev_q  <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= rst_take;
      if (rst_take) rlev_q <= bus_wdata;
    end
  end

  logic [31:0] disp_q;
  logic        disp_wr;
  assign disp_wr = bus_wr && hit(bus_addr, OFF_DISP);

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_q  <= (board == BRD_VX) ? 32'h0 : DISP_RESET;
      fmt_mux <= 2'b00;
    end else if (disp_wr) begin
      unique case (board)
        BRD_A, BRD_B: disp_q <= (disp_q & DISP_RO_AB) | (bus_wdata & ~DISP_RO_AB);
        BRD_C, BRD_D: disp_q <= (disp_q & DISP_RO_CD) | (bus_wdata & ~DISP_RO_CD);
        default:      disp_q <= disp_q;
      endcase
      if (board == BRD_A) fmt_mux <= bus_wdata[1:0];
    end
  end

  logic [31:0] tick_cnt;
  sysctl_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .W(32)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .count (tick_cnt)
  );

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit(bus_addr, OFF_LOCK))          rd_mux = {15'h0, unlocked, key_q};
    else if (hit(bus_addr, OFF_FLAG_SET)) rd_mux = flag_val[0];
    else if (hit(bus_addr, OFF_NV_SET))   rd_mux = flag_val[1];
    else if (hit(bus_addr, OFF_RSTCTL))   rd_mux = (board == BRD_VX) ? 32'h0 : rlev_q;
    else if (hit(bus_addr, OFF_DISP))     rd_mux = disp_q;
    else if (hit(bus_addr, OFF_TICK))     rd_mux = tick_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       sys_id,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              rst_req,
  input logic [1:0]        fmt_mux,
  input logic [31:0]       tick_cnt
);
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req); // R4
  AST_RST_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(bus_wr && bus_addr == ADDR_W'('h40))); // R4
  AST_RST_NONE_VX: assert property (@(posedge clk) disable iff (rst)
    (sys_id[27:16] == 12'h190) |-> !rst_req); // R5
  AST_MUX_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !$stable(fmt_mux) |-> $past(bus_wr && bus_addr == ADDR_W'('h50) && sys_id[27:16] == 12'h100)); // R7
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick_cnt == $past(tick_cnt)) || (tick_cnt == $past(tick_cnt) + 32'd1)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata)); // R11
endmodule

bind sysctl_regs sysctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sys_id    (sys_id),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .rst_req   (rst_req),
  .fmt_mux   (fmt_mux),
  .tick_cnt  (tick_cnt)
);

// File: tb/sysctl_regs_bench.sv
module sysctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] sys_id = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  logic [1:0]  fmt_mux;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sysctl_regs u_sysctl_regs (
    .clk(clk), .rst(rst), .sys_id(sys_id), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req), .fmt_mux(fmt_mux)
  );

  // model state
  logic [11:0] m_brd;
  logic [15:0] m_key;
  logic [31:0] m_flag, m_nv, m_rlev, m_disp;
  logic [1:0]  m_mux;

  function automatic logic [31:0] disp_next(input logic [11:0] b, input logic [31:0] o, input logic [31:0] v);
    if (b == 12'h100 || b == 12'h140) return (o & 32'h3F00) | (v & ~32'h3F00);
    if (b == 12'h178 || b == 12'h182) return (o & 32'h80) | (v & ~32'h80);
    return o;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h020: return {15'h0, (m_key == 16'hA05F), m_key};
      12'h030: return m_flag;
      12'h038: return m_nv;
      12'h040: return (m_brd == 12'h190) ? 32'h0 : m_rlev;
      12'h050: return m_disp;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_rst(input logic [11:0] b);
    @(negedge clk);
    sys_id = {4'hA, b, 16'h5A5A};
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_brd = b; m_key = '0; m_flag = '0; m_nv = '0; m_rlev = '0;
    m_disp = (b == 12'h190) ? 32'h0 : 32'h1F00;
    m_mux = 2'b00;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic take;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    take = (a == 12'h040) && (m_key == 16'hA05F) && (m_brd != 12'h190);
    case (a)
      12'h020: m_key = (d == 32'hA05F) ? 16'hA05F : {1'b0, d[14:0]};
      12'h030: m_flag = m_flag | d;
      12'h034: m_flag = m_flag & ~d;
      12'h038: m_nv = m_nv | d;
      12'h03C: m_nv = m_nv & ~d;
      12'h040: if (take) m_rlev = d;
      12'h050: begin
        m_disp = disp_next(m_brd, m_disp, d);
        if (m_brd == 12'h100) m_mux = d[1:0];
      end
      default: ;
    endcase
    @(negedge clk);
    bus_wr = 1'b0;
    check("R4 rst_req pulse", {31'h0, rst_req}, {31'h0, take});
    if (a == 12'h050) check("R7 fmt_mux", {30'h0, fmt_mux}, {30'h0, m_mux});
    if (take) begin
      @(negedge clk);
      check("R4 rst_req one cycle", {31'h0, rst_req}, 32'h0);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] q);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    q = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a);
    logic [31:0] q;
    rd(a, q);
    check(req, q, exp_read(a));
  endtask

  localparam logic [11:0] BOARDS [6] = '{12'h100, 12'h140, 12'h178, 12'h182, 12'h190, 12'h0AB};
  localparam logic [11:0] ADDRS [10] = '{12'h020, 12'h030, 12'h034, 12'h038, 12'h03C,
                                         12'h040, 12'h050, 12'h044, 12'h7F0, 12'h054};

  initial begin
    logic [31:0] q, t0, t1;
    void'($urandom(32'd1234));
    for (int bi = 0; bi < 6; bi++) begin
      do_rst(BOARDS[bi]);
      // reset state (R1 R3 R4 R9 R5)
      rd_chk("R1 lock reset", 12'h020);
      rd_chk("R3 flags reset", 12'h030);
      rd_chk("R3 nv flags reset", 12'h038);
      rd_chk("R4 reset level reset", 12'h040);
      rd_chk("R9 display reset", 12'h050);
      check("R7 fmt_mux reset", {30'h0, fmt_mux}, 32'h0);
      // locked write to reset control
      wr(12'h040, 32'h1234_5678);
      rd_chk("R4 locked write ignored", 12'h040);
      // near-key values keep the block locked
      wr(12'h020, 32'h0001_A05F);
      rd_chk("R1 near key stays locked", 12'h020);
      wr(12'h040, 32'hDEAD_0001);
      rd_chk("R4 near key write ignored", 12'h040);
      wr(12'h020, 32'h0000_A05F);
      rd_chk("R1 key unlocks", 12'h020);
      wr(12'h040, 32'h0000_0104);
      rd_chk("R4 R5 unlocked reset write", 12'h040);
      // display corners
      wr(12'h050, 32'hFFFF_FFFF);
      rd_chk("R6 R8 R5 R9 display all ones", 12'h050);
      wr(12'h050, 32'h0000_0002);
      rd_chk("R6 R8 display low", 12'h050);
      // R2: upper ID bits must not matter
      for (int k = 0; k < 300; k++) begin
        logic [11:0] a;
        logic [31:0] d;
        a = ADDRS[$urandom_range(0, 9)];
        d = $urandom();
        if (a == 12'h020 && $urandom_range(0, 1) == 1) d = 32'hA05F;
        if ($urandom_range(0, 1) == 1) wr(a, d);
        else rd_chk("R2 R3 R11 random read", a);
      end
      rd_chk("R3 flags final", 12'h030);
      rd_chk("R3 nv flags final", 12'h038);
      rd_chk("R11 unmapped", 12'h044);
      rd_chk("R11 clear offset reads zero", 12'h034);
    end
    // R11: rdata holds without read
    rd(12'h050, q);
    repeat (5) @(negedge clk);
    check("R11 rdata hold", bus_rdata, q);
    // R10: counter rate
    rd(12'h05C, t0);
    repeat (998) @(negedge clk);
    rd(12'h05C, t1);
    check("R10 tick rate", t1 - t0, 32'd96);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule